// File: doc/BRIEF.md
# Power-Gate Header Stepping Controller

This block drives the eight enables of one rail's header-switch array. Software puts a two-bit force command into a 64-bit control word. The sequencer then turns the enables on one at a time from the lowest upward, or turns them off from the highest downward. After each change it waits a programmable settling time. That time is exponential in a four-bit code, and there is one code for ramping up and another for ramping down.

The control word can be written in three ways: a whole-word put, an OR-set that only raises bits, and a clear that lowers every bit written as one. A separate put writes the delay word. The control word also shows the sequencer state and the actual enable value; these fields are read-only. Two override bits can take the enables away from the sequencer. One override drives them from a raw software byte. The other builds a thermometer from a stage count. Two flags report when the rail is fully on or fully off and the sequencer is at rest.

Top module: `pgate_step_ctrl`

## Requirements
- R1: Control bits [1:0] hold the force command: 2'b11 ramps the enables on, 2'b01 ramps them off, and 2'b00 and the reserved 2'b10 start nothing and leave the enables unchanged.
- R2: A ramp up sets one enable per step, starting at bit 0 and moving upward. A ramp down clears one enable per step, starting at bit 7 and moving downward. The sequencer's enables are always a thermometer (ones from bit 0).
- R3: The first enable changes two clocks after the edge that writes the force command. Each later change comes D+1 clocks after the previous one, and the sequencer returns to idle D clocks after the last change. D = UNIT_CLKS * 2^(EXP_TOP - code), and codes at or above EXP_TOP give D = UNIT_CLKS. The up code is delay bits [7:4] and the down code is delay bits [3:0].
- R4: Control read bits [21:20] show the sequencer state: 0 idle, 1 increment, 2 decrement, 3 wait. The increment and decrement states each last one clock and are always followed by wait.
- R5: all_on is high only when the enables are 8'hFF and the state is idle. all_off is high only when the enables are 8'h00 and the state is idle.
- R6: wr_op selects the write: 0 puts the control word, 1 ORs into it, 2 clears the bits written as one, and 3 puts the delay word. Only bits [1:0], [3:2], [15:8] and [19:16] of the control word are writable. Only bits [7:0] of the delay word are stored. Every other bit reads as zero, except the read-only state at [21:20] and the actual enables at [31:24].
- R7: When control bit 2 is set, en_out equals the raw byte at bits [15:8]. Otherwise, when bit 3 is set, en_out is a thermometer of the count at bits [19:16], and counts above 8 saturate to 8'hFF. The sequencer's own vector is kept and returns when both bits are clear.
- R8: When the force command drops to no-op during a ramp, the step in progress finishes its wait and the sequencer goes idle, holding the enables. At the end of a wait, the next step depends on the command as it stood before that edge.
- R9: After reset the control and delay words are zero, en_out is 0, all_off is 1 and all_on is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| wr_op | input | 2 | Write kind: control put, OR-set, clear, delay put |
| wr_data | input | 64 | Write data word |
| ctrl_rd | output | 64 | Control word with read-only state and actual enables |
| dly_rd | output | 64 | Delay word: down code [3:0], up code [7:4] |
| en_out | output | 8 | Enables toward the header switches |
| all_on | output | 1 | All enables on and sequencer idle |
| all_off | output | 1 | All enables off and sequencer idle |

## Verification
Two events can land on the same edge: a clear write that drops the force command, and the expiry of a step's wait. The bench provokes both orders. It aligns the clear with the expiry edge itself, which must still produce one more step. It also aligns the clear with the edge just before, which must leave the vector where it stood. The final enable vector and the idle state field decide which outcome occurred.

// File: rtl/pgate_pkg.sv
// Shared types and field positions for the power-gate stepping controller.
// Assumes an 8-stage header array and 4-bit delay codes.
package pgate_pkg;
    localparam int PG_STAGES = 8;
    localparam int PG_CODE_W = 4;
    localparam int PG_CNT_W  = 4;
    localparam int PG_WORD_W = 64;

    // Control word field positions
    localparam int F_FRC_LSB   = 0;
    localparam int F_VOVR_BIT  = 2;
    localparam int F_SOVR_BIT  = 3;
    localparam int F_RAW_LSB   = 8;
    localparam int F_CNT_LSB   = 16;
    localparam int F_STATE_LSB = 20;
    localparam int F_ACT_LSB   = 24;
    // Delay word field positions
    localparam int F_DN_LSB    = 0;
    localparam int F_UP_LSB    = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_INC  = 2'd1,
        SEQ_DEC  = 2'd2,
        SEQ_WAIT = 2'd3
    } seq_state_e;

    localparam logic [1:0] FRC_NONE = 2'b00;
    localparam logic [1:0] FRC_OFF  = 2'b01;
    localparam logic [1:0] FRC_RSVD = 2'b10;
    localparam logic [1:0] FRC_ON   = 2'b11;

    localparam logic [1:0] OP_CTRL_PUT = 2'd0;
    localparam logic [1:0] OP_CTRL_SET = 2'd1;
    localparam logic [1:0] OP_CTRL_CLR = 2'd2;
    localparam logic [1:0] OP_DLY_PUT  = 2'd3;

    typedef struct packed {
        logic [PG_CNT_W-1:0]  cnt;
        logic [PG_STAGES-1:0] raw;
        logic                 sel_ovr;
        logic                 val_ovr;
        logic [1:0]           frc;
    } ctrl_t;

    // Extract the writable control fields from a bus word.
    function automatic ctrl_t word_to_ctrl(input logic [PG_WORD_W-1:0] w);
        ctrl_t c;
        c.frc     = w[F_FRC_LSB +: 2];
        c.val_ovr = w[F_VOVR_BIT];
        c.sel_ovr = w[F_SOVR_BIT];
        c.raw     = w[F_RAW_LSB +: PG_STAGES];
        c.cnt     = w[F_CNT_LSB +: PG_CNT_W];
        return c;
    endfunction
endpackage

// File: rtl/pgate_regs.sv
// Control and delay storage with put, OR-set and clear write kinds.
// Assumes single-cycle write strobes; read-only fields live elsewhere.
module pgate_regs
    import pgate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_op,
    input  logic [PG_WORD_W-1:0] wr_data,
    output ctrl_t                ctrl_q,
    output logic [PG_CODE_W-1:0] up_code,
    output logic [PG_CODE_W-1:0] dn_code
);
    ctrl_t wr_f;

    // Map the incoming word onto the writable fields
    always_comb wr_f = word_to_ctrl(wr_data);

    // Apply the selected write kind to the stored words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            up_code <= '0;
            dn_code <= '0;
        end else if (wr_en) begin
            case (wr_op)
                OP_CTRL_PUT: ctrl_q <= wr_f;
                OP_CTRL_SET: ctrl_q <= ctrl_q | wr_f;
                OP_CTRL_CLR: ctrl_q <= ctrl_q & ~wr_f;
                default: begin
                    up_code <= wr_data[F_UP_LSB +: PG_CODE_W];
                    dn_code <= wr_data[F_DN_LSB +: PG_CODE_W];
                end
            endcase
        end
    end
endmodule

// File: rtl/pgate_timer.sv
// Step settling counter: loads UNIT_CLKS << (EXP_TOP - code) minus one and
// counts down; done is high while the count is zero. Codes at or above
// EXP_TOP saturate to the shortest span.
module pgate_timer
    import pgate_pkg::*;
#(
    parameter int UNIT_CLKS = 4,
    parameter int EXP_TOP   = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [PG_CODE_W-1:0] code,
    output logic                 done
);
    localparam int MAX_SPAN = UNIT_CLKS * (2 ** EXP_TOP);
    localparam int CNT_W    = $clog2(MAX_SPAN + 1);
    localparam int SH_W     = $clog2(EXP_TOP + 2);
    localparam logic [CNT_W-1:0] UNIT_V = CNT_W'(UNIT_CLKS);

    logic [SH_W-1:0]  shamt;
    logic [CNT_W-1:0] span;
    logic [CNT_W-1:0] cnt_q;

    // Exponent from the code, saturating at zero
    always_comb begin
        if (int'(code) >= EXP_TOP) shamt = '0;
        else                       shamt = SH_W'(EXP_TOP - int'(code));
        span = UNIT_V << shamt;
    end

    // Reload on a step, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= span - CNT_W'(1);
        else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pgate_seq.sv
// Stepping state machine: increments the enable thermometer from bit 0,
// decrements from the top, and waits for the timer between steps.
// The force command is sampled in idle and at the end of each wait.
module pgate_seq
    import pgate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           frc,
    input  logic                 done,
    output seq_state_e           state,
    output logic [PG_STAGES-1:0] vec,
    output logic                 load,
    output logic                 step_up
);
    seq_state_e next_step;

    // Choose the next step from the command and the current vector
    always_comb begin
        if (frc == FRC_ON && vec != '1)        next_step = SEQ_INC;
        else if (frc == FRC_OFF && vec != '0)  next_step = SEQ_DEC;
        else                                   next_step = SEQ_IDLE;
    end

    // Advance the sequencer and update the vector on step states
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            vec   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: state <= next_step;
                SEQ_INC: begin
                    vec   <= vec | (vec + PG_STAGES'(1));
                    state <= SEQ_WAIT;
                end
                SEQ_DEC: begin
                    vec   <= vec >> 1;
                    state <= SEQ_WAIT;
                end
                default: if (done) state <= next_step;
            endcase
        end
    end

    assign load    = (state == SEQ_INC) || (state == SEQ_DEC);
    assign step_up = (state == SEQ_INC);
endmodule

// File: rtl/pgate_outmux.sv
// Output selection: raw override first, then stage-count thermometer,
// otherwise the sequencer vector.
module pgate_outmux
    import pgate_pkg::*;
(
    input  ctrl_t                ctrl,
    input  logic [PG_STAGES-1:0] vec,
    output logic [PG_STAGES-1:0] en_out
);
    logic [PG_STAGES-1:0] thermo;

    // One comparator per stage builds the count thermometer
    for (genvar i = 0; i < PG_STAGES; i++) begin : g_thermo
        assign thermo[i] = (int'(ctrl.cnt) > i);
    end

    // Priority selection of the enable source
    always_comb begin
        if (ctrl.val_ovr)      en_out = ctrl.raw;
        else if (ctrl.sel_ovr) en_out = thermo;
        else                   en_out = vec;
    end
endmodule

// File: rtl/pgate_step_ctrl.sv
// Top of the power-gate stepping controller: registers, sequencer, timer
// and output selection, plus read-back assembly and rest flags.
// Assumes one rail and synchronous active-low reset.
module pgate_step_ctrl
    import pgate_pkg::*;
#(
    parameter int UNIT_CLKS = 4,
    parameter int EXP_TOP   = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_op,
    input  logic [63:0] wr_data,
    output logic [63:0] ctrl_rd,
    output logic [63:0] dly_rd,
    output logic [7:0]  en_out,
    output logic        all_on,
    output logic        all_off
);
    ctrl_t                ctrl_q;
    logic [PG_CODE_W-1:0] up_code;
    logic [PG_CODE_W-1:0] dn_code;
    logic [PG_CODE_W-1:0] step_code;
    seq_state_e           state;
    logic [PG_STAGES-1:0] vec;
    logic                 load;
    logic                 step_up;
    logic                 done;

    pgate_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_op   (wr_op),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .up_code (up_code),
        .dn_code (dn_code)
    );

    pgate_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .frc     (ctrl_q.frc),
        .done    (done),
        .state   (state),
        .vec     (vec),
        .load    (load),
        .step_up (step_up)
    );

    // Pick the settling code for the step being taken
    always_comb step_code = step_up ? up_code : dn_code;

    pgate_timer #(
        .UNIT_CLKS (UNIT_CLKS),
        .EXP_TOP   (EXP_TOP)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .code  (step_code),
        .done  (done)
    );

    pgate_outmux u_mux (
        .ctrl   (ctrl_q),
        .vec    (vec),
        .en_out (en_out)
    );

    // Assemble the control read-back word
    always_comb begin
        ctrl_rd                           = '0;
        ctrl_rd[F_FRC_LSB +: 2]           = ctrl_q.frc;
        ctrl_rd[F_VOVR_BIT]               = ctrl_q.val_ovr;
        ctrl_rd[F_SOVR_BIT]               = ctrl_q.sel_ovr;
        ctrl_rd[F_RAW_LSB +: PG_STAGES]   = ctrl_q.raw;
        ctrl_rd[F_CNT_LSB +: PG_CNT_W]    = ctrl_q.cnt;
        ctrl_rd[F_STATE_LSB +: 2]         = state;
        ctrl_rd[F_ACT_LSB +: PG_STAGES]   = en_out;
    end

    // Assemble the delay read-back word
    always_comb begin
        dly_rd                       = '0;
        dly_rd[F_DN_LSB +: PG_CODE_W] = dn_code;
        dly_rd[F_UP_LSB +: PG_CODE_W] = up_code;
    end

    // Rest flags for the rail
    always_comb begin
        all_on  = (state == SEQ_IDLE) && (&en_out);
        all_off = (state == SEQ_IDLE) && !(|en_out);
    end
endmodule

// File: rtl/pgate_step_ctrl_chk.sv
// Property checker for the stepping controller, observing only top ports.
module pgate_step_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_op,
    input logic [63:0] wr_data,
    input logic [63:0] ctrl_rd,
    input logic [7:0]  en_out,
    input logic        all_on,
    input logic        all_off
);
    logic [1:0] st;
    logic [1:0] frc;
    logic       ovr;

    // Decode read-back fields used by the properties
    always_comb begin
        st  = ctrl_rd[21:20];
        frc = ctrl_rd[1:0];
        ovr = ctrl_rd[2] | ctrl_rd[3];
    end

    // R2: sequencer-driven enables form a thermometer
    p_thermo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr |-> ((en_out & (en_out + 8'd1)) == 8'd0));

    // R2: at most one enable moves per clock without override
    p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && $past(!ovr)) |-> ($countones(en_out ^ $past(en_out)) <= 1));

    // R3: enables only move right after a step state
    p_move_on_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && $past(!ovr) && en_out != $past(en_out))
            |-> ($past(st) == 2'd1 || $past(st) == 2'd2));

    // R4: a step state is always followed by wait
    p_step_then_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd1 || st == 2'd2) |=> (st == 2'd3));

    // R8: idle with a no-op command holds the enables
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd0 && !frc[0] && !ovr) |=> (ovr || $stable(en_out)));

    // R6: a clear write lowers the written force bits
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 2'd2) |=> ((frc & $past(wr_data[1:0])) == 2'b00));

    // R6: an OR-set write raises the written force bits
    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 2'd1) |=> ((frc & $past(wr_data[1:0])) == $past(wr_data[1:0])));

    // R5: rest flags are never high together
    p_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(all_on && all_off));

    // R7: raw override shows the raw byte on the enables
    p_val_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[2] |-> (en_out == ctrl_rd[15:8]));
endmodule

bind pgate_step_ctrl pgate_step_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_op   (wr_op),
    .wr_data (wr_data),
    .ctrl_rd (ctrl_rd),
    .en_out  (en_out),
    .all_on  (all_on),
    .all_off (all_off)
);

// File: tb/pgate_step_ctrl_bench.sv
// Bench for the stepping controller in a small configuration
// (UNIT_CLKS=2, EXP_TOP=3): sweeps every up and down code and the corner cases.
module pgate_step_ctrl_bench;
    localparam int UC = 2;
    localparam int ET = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_op = 2'd0;
    logic [63:0] wr_data = '0;
    logic [63:0] ctrl_rd;
    logic [63:0] dly_rd;
    logic [7:0]  en_out;
    logic        all_on;
    logic        all_off;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pgate_step_ctrl #(.UNIT_CLKS(UC), .EXP_TOP(ET)) u_pgate_step_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_op   (wr_op),
        .wr_data (wr_data),
        .ctrl_rd (ctrl_rd),
        .dly_rd  (dly_rd),
        .en_out  (en_out),
        .all_on  (all_on),
        .all_off (all_off)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [1:0] op, input logic [63:0] d);
        wr_en = 1'b1; wr_op = op; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_op = 2'd0; wr_data = '0;
    endtask

    function automatic int span(input int code);
        int sh;
        sh = (code >= ET) ? 0 : ET - code;
        return UC << sh;
    endfunction

    // Time one full ramp; starts at the falling edge after the force write
    task automatic ramp(input bit up, input int d);
        logic [7:0] prev;
        logic [7:0] expv;
        int n;
        for (int s = 0; s < 8; s++) begin
            prev = en_out;
            n = 0;
            while (en_out == prev && n < 4000) begin
                @(posedge clk); @(negedge clk); n++;
            end
            expv = up ? 8'((16'd1 << (s + 1)) - 16'd1) : 8'(8'hFF >> (s + 1));
            chk("R2 step value", {56'd0, en_out}, {56'd0, expv});
            chk("R3 step spacing", 64'(n), 64'((s == 0) ? 2 : d + 1));
            if (s == 0) chk("R4 wait state", {62'd0, ctrl_rd[21:20]}, 64'd3);
        end
        n = 0;
        while (!(up ? all_on : all_off) && n < 4000) begin
            @(posedge clk); @(negedge clk); n++;
        end
        chk("R5 R3 rest after last step", 64'(n), 64'(d));
        chk("R4 idle state", {62'd0, ctrl_rd[21:20]}, 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset values
        chk("R9 en_out", {56'd0, en_out}, 64'd0);
        chk("R9 ctrl word", ctrl_rd, 64'd0);
        chk("R9 delay word", dly_rd, 64'd0);
        chk("R9 flags", {62'd0, all_on, all_off}, 64'd1);

        // R3 R2 R1: exhaustive sweep of up and down codes
        for (int c = 0; c < 16; c++) begin
            wr(2'd3, 64'((c << 4) | (15 - c)));
            chk("R6 delay put", dly_rd, 64'((c << 4) | (15 - c)));
            wr(2'd1, 64'd3);
            ramp(1'b1, span(c));
            wr(2'd2, 64'd3);
            wr(2'd1, 64'd1);
            ramp(1'b0, span(15 - c));
            wr(2'd2, 64'd3);
        end

        // R1 reserved command starts nothing
        wr(2'd1, 64'd2);
        chk("R1 reserved stored", {62'd0, ctrl_rd[1:0]}, 64'd2);
        repeat (40) @(negedge clk);
        chk("R1 reserved no change", {56'd0, en_out}, 64'd0);
        chk("R1 reserved idle", {62'd0, ctrl_rd[21:20]}, 64'd0);
        wr(2'd2, 64'd3);

        // R8 clear one edge before wait expiry: vector stops at 8'h01
        wr(2'd3, 64'h22);
        d = span(2);
        wr(2'd1, 64'd3);
        while (en_out == 8'h00) @(negedge clk);
        repeat (d - 2) @(negedge clk);
        wr(2'd2, 64'd3);
        repeat (40) @(negedge clk);
        chk("R8 early cancel vector", {56'd0, en_out}, 64'h01);
        chk("R8 early cancel idle", {62'd0, ctrl_rd[21:20]}, 64'd0);

        // R8 clear on the expiry edge: one more step, vector 8'h07
        wr(2'd1, 64'd3);
        while (en_out == 8'h01) @(negedge clk);
        repeat (d - 1) @(negedge clk);
        wr(2'd2, 64'd3);
        repeat (40) @(negedge clk);
        chk("R8 same-edge cancel vector", {56'd0, en_out}, 64'h07);
        chk("R8 same-edge cancel idle", {62'd0, ctrl_rd[21:20]}, 64'd0);

        // R7 raw override
        wr(2'd0, 64'h0000_A504);
        chk("R7 raw override", {56'd0, en_out}, 64'hA5);
        chk("R7 actual readback", {56'd0, ctrl_rd[31:24]}, 64'hA5);
        chk("R5 flags mid value", {62'd0, all_on, all_off}, 64'd0);
        wr(2'd0, 64'h0000_FF04);
        chk("R5 all_on under override", {62'd0, all_on, all_off}, 64'd2);

        // R7 stage count sweep with saturation
        for (int c = 0; c < 16; c++) begin
            wr(2'd0, 64'((c << 16) | 8));
            chk("R7 count thermometer", {56'd0, en_out},
                64'((c >= 8) ? 8'hFF : 8'((16'd1 << c) - 16'd1)));
        end
        wr(2'd0, 64'h8);
        chk("R5 all_off under override", {62'd0, all_on, all_off}, 64'd1);

        // R7 raw override wins over count override
        wr(2'd0, 64'h0005_3C0C);
        chk("R7 priority", {56'd0, en_out}, 64'h3C);

        // R6 put ignores read-only and unused bits; vector returns (R7)
        wr(2'd0, 64'hFFFF_FFFF_FF30_00F0);
        chk("R6 put masks read-only", ctrl_rd, 64'h0000_0000_0700_0000);
        chk("R7 vector restored", {56'd0, en_out}, 64'h07);

        // R6 OR-set and clear
        wr(2'd1, 64'h5500);
        wr(2'd1, 64'h0A00);
        chk("R6 OR-set", {56'd0, ctrl_rd[15:8]}, 64'h5F);
        wr(2'd2, 64'h1500);
        chk("R6 clear", {56'd0, ctrl_rd[15:8]}, 64'h4A);
        wr(2'd2, '1);
        chk("R6 clear all", ctrl_rd, 64'h0000_0000_0700_0000);
        wr(2'd3, '1);
        chk("R6 delay width", dly_rd, 64'hFF);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule